// File: doc/BRIEF.md
# Device-Side Interrupt Request Controller for a Parallel Disk Interface

This block sits on the device side of a parallel disk interface. It holds the interrupt-pending flag and drives the interrupt request line towards the host. The line is given as a data value plus an output enable, so the pad can be released to high impedance. The device core raises a pending request. The host's register accesses lower it or change where it is seen: a status read, a command write, and a device-select write that carries the drive-select bit.

The register file decodes those accesses and hands this block single-cycle event pulses, each timed at the negation of the host strobe. The interrupt-disable bit arrives as a level. A strap input says whether this unit answers as device 0 or device 1. The clock frequency is a parameter. The 400 ns response limit and the 40 ns minimum pulse width are turned into cycle counts from it.

Top module: `ata_irq_ctrl`

## Requirements
- R1: After reset the pending flag is clear and `intrq_o` is 0. `intrq_oe` is 1 only when the strap `dev_id_i` is 0, because device 0 is selected at reset.
- R2: `intrq_oe` is 1 only while this device is selected and `irq_dis_i` is 0. Whenever `intrq_oe` is 0, `intrq_o` is also 0. While `intrq_oe` is 1, `intrq_o` follows the pending flag.
- R3: A status-read event (`stat_rd_i`) clears the pending flag. The driven line then goes low.
- R4: A command-write event (`cmd_wr_i`) clears the pending flag. The driven line then goes low.
- R5: A device-select write (`dev_wr_i`) that selects this device while pending is set makes the line driven high.
- R6: A device-select write that deselects this device releases the line (`intrq_oe` = 0). The pending flag is kept, so selecting the device again drives the line high without a new request.
- R7: Once `intrq_o` has gone high, it stays driven high for at least MIN_PULSE cycles, where MIN_PULSE = ceil(40 ns × CLK_MHZ / 1000). This holds even if the device is disabled or deselected in the meantime.
- R8: If `pend_set_i` arrives in the same cycle as a clear event, the set wins and pending stays 1.
- R9: Every output change demanded by an event or by the disable input happens within LIMIT cycles, where LIMIT = floor(400 ns × CLK_MHZ / 1000). Without a pulse hold the delay is two cycles.
- R10: A device-select write selects this device when the written select bit `dev_sel_i` equals `dev_id_i` (0 = device 0, 1 = device 1). Any other value deselects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id_i | input | 1 | Strap: 0 = device 0, 1 = device 1 |
| irq_dis_i | input | 1 | Interrupt-disable bit (1 = disabled) |
| pend_set_i | input | 1 | Pulse from the core: set interrupt pending |
| stat_rd_i | input | 1 | Pulse: status register read completed |
| cmd_wr_i | input | 1 | Pulse: command register write completed |
| dev_wr_i | input | 1 | Pulse: device-select register write completed |
| dev_sel_i | input | 1 | Drive-select bit of that device-select write |
| intrq_o | output | 1 | Interrupt request value |
| intrq_oe | output | 1 | Output enable for the interrupt request pad |

## Verification
The hardest case to reach is the minimum-pulse hold. The disable bit has to rise just after the line goes high, so that the line would otherwise drop at once. The bench waits until it samples the line high, then raises the disable bit on the following negative edge. It then counts how many cycles the line stays driven and checks that it is released afterwards. A second sequence hides a pending flag by deselecting the device and then selects it again. This shows that the flag survived, using only the port pins.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;

    // Host register events, each a single-cycle pulse at strobe negation
    typedef struct packed {
        logic stat_rd;
        logic cmd_wr;
        logic dev_wr;
        logic dev_sel;
    } reg_evt_t;

    // Pad drive pair
    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    // Number of whole cycles that fit in ns at clk_mhz (rounded down)
    function automatic int ns_to_cyc_floor(input int ns, input int clk_mhz);
        return (ns * clk_mhz) / 1000;
    endfunction

    // Number of cycles needed to cover ns at clk_mhz (rounded up, at least 1)
    function automatic int ns_to_cyc_ceil(input int ns, input int clk_mhz);
        int c;
        c = (ns * clk_mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/ata_irq_sel.sv
module ata_irq_sel
    import ata_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dev_id,
    input  reg_evt_t evt,
    output logic     selected
);

    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= ~dev_id;
        else if (evt.dev_wr)
            sel_q <= (evt.dev_sel == dev_id);
    end

    assign selected = sel_q;

    // R10
    sel_match_chk: assert property (@(posedge clk) disable iff (rst)
        evt.dev_wr |=> (sel_q == ($past(evt.dev_sel) == $past(dev_id))));

    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.dev_wr |=> $stable(sel_q));

endmodule

// File: rtl/ata_irq_pend.sv
module ata_irq_pend
    import ata_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_req,
    input  reg_evt_t evt,
    output logic     pending
);

    logic pend_q;
    logic clr;

    assign clr = evt.stat_rd | evt.cmd_wr;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (set_req)
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end

    assign pending = pend_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> pend_q);

    // R3
    clear_on_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_req) |=> !pend_q);

    // R6
    pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set_req) |=> $stable(pend_q));

endmodule

// File: rtl/ata_irq_drive.sv
module ata_irq_drive
    import ata_irq_pkg::*;
#(
    parameter int MIN_PULSE = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     selected,
    input  logic     irq_dis,
    input  logic     pending,
    output pad_drv_t drv
);

    localparam int HW = $clog2(MIN_PULSE + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(MIN_PULSE - 1);

    pad_drv_t       drv_q, drv_d;
    logic [HW-1:0]  hold_q, hold_d;
    logic           enable;

    assign enable = selected & ~irq_dis;

    always_comb begin
        drv_d  = drv_q;
        hold_d = hold_q;
        if (drv_q.val && hold_q != '0) begin
            hold_d = hold_q - 1'b1;
        end else begin
            drv_d.oe  = enable;
            drv_d.val = enable & pending;
            hold_d    = '0;
            if (drv_d.val && !drv_q.val)
                hold_d = HOLD_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= '0;
            hold_q <= '0;
        end else begin
            drv_q  <= drv_d;
            hold_q <= hold_d;
        end
    end

    assign drv = drv_q;

    // R2
    val_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        drv_q.val |-> drv_q.oe);

    // R7
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_q.val && hold_q != '0) |=> drv_q.val);

    // R7
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_q.val) |-> (hold_q == HOLD_LOAD));

endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl
    import ata_irq_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int LIMIT_NS  = 400,
    parameter int PULSE_NS  = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic dev_id_i,
    input  logic irq_dis_i,
    input  logic pend_set_i,
    input  logic stat_rd_i,
    input  logic cmd_wr_i,
    input  logic dev_wr_i,
    input  logic dev_sel_i,
    output logic intrq_o,
    output logic intrq_oe
);

    localparam int LIMIT     = ns_to_cyc_floor(LIMIT_NS, CLK_MHZ);
    localparam int MIN_PULSE = ns_to_cyc_ceil(PULSE_NS, CLK_MHZ);
    localparam int LW        = $clog2(LIMIT + 2);

    reg_evt_t evt;
    logic     selected;
    logic     pending;
    pad_drv_t drv;

    assign evt = '{stat_rd: stat_rd_i, cmd_wr: cmd_wr_i,
                   dev_wr: dev_wr_i, dev_sel: dev_sel_i};

    ata_irq_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .dev_id   (dev_id_i),
        .evt      (evt),
        .selected (selected)
    );

    ata_irq_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_req (pend_set_i),
        .evt     (evt),
        .pending (pending)
    );

    ata_irq_drive #(.MIN_PULSE(MIN_PULSE)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .selected (selected),
        .irq_dis  (irq_dis_i),
        .pending  (pending),
        .drv      (drv)
    );

    assign intrq_o  = drv.val;
    assign intrq_oe = drv.oe;

    // Latency watch: cycles the pad has disagreed with the settled target
    logic          tgt_oe, tgt_val, mismatch;
    logic [LW-1:0] lag_q;

    assign tgt_oe   = selected & ~irq_dis_i;
    assign tgt_val  = tgt_oe & pending;
    assign mismatch = (intrq_oe != tgt_oe) || (intrq_o != tgt_val);

    always_ff @(posedge clk) begin
        if (rst)
            lag_q <= '0;
        else if (!mismatch)
            lag_q <= '0;
        else if (lag_q != LW'(LIMIT + 1))
            lag_q <= lag_q + 1'b1;
    end

    // R9
    resp_limit_chk: assert property (@(posedge clk) disable iff (rst)
        lag_q < LW'(LIMIT));

    // R2
    released_low_chk: assert property (@(posedge clk) disable iff (rst)
        !intrq_oe |-> !intrq_o);

endmodule

// File: tb/ata_irq_ctrl_tb_top.sv
module ata_irq_ctrl_tb_top;

    localparam int MIN_PULSE = 5;   // ceil(40 ns * 125 MHz)
    localparam int LIMIT     = 50;  // 400 ns at 125 MHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_id = 1'b0, irq_dis = 1'b0, pend_set = 1'b0;
    logic stat_rd = 1'b0, cmd_wr = 1'b0, dev_wr = 1'b0, dev_sel = 1'b0;
    logic intrq_o, intrq_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ata_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .dev_id_i(dev_id), .irq_dis_i(irq_dis),
        .pend_set_i(pend_set), .stat_rd_i(stat_rd), .cmd_wr_i(cmd_wr),
        .dev_wr_i(dev_wr), .dev_sel_i(dev_sel),
        .intrq_o(intrq_o), .intrq_oe(intrq_oe)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: oe/val actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic id);
        @(negedge clk);
        rst = 1'b1; dev_id = id; irq_dis = 1'b0;
        wait_neg(2);
        rst = 1'b0;
        wait_neg(1);
    endtask

    // one-cycle event pulses, applied at a negative edge
    task automatic ev_set();    pend_set = 1'b1; wait_neg(1); pend_set = 1'b0; endtask
    task automatic ev_stat();   stat_rd  = 1'b1; wait_neg(1); stat_rd  = 1'b0; endtask
    task automatic ev_cmd();    cmd_wr   = 1'b1; wait_neg(1); cmd_wr   = 1'b0; endtask
    task automatic ev_dev(input logic s);
        dev_wr = 1'b1; dev_sel = s; wait_neg(1); dev_wr = 1'b0; dev_sel = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 dev0 reset", {intrq_oe, intrq_o}, 2'b10);
    endtask

    task automatic t_status_clear();
        do_reset(1'b0);
        ev_set(); wait_neg(2);
        check("R2 pending driven", {intrq_oe, intrq_o}, 2'b11);
        wait_neg(MIN_PULSE);
        ev_stat(); wait_neg(2);
        check("R3 status read clears", {intrq_oe, intrq_o}, 2'b10);
    endtask

    task automatic t_cmd_clear();
        do_reset(1'b0);
        ev_set(); wait_neg(MIN_PULSE + 2);
        ev_cmd(); wait_neg(2);
        check("R4 command write clears", {intrq_oe, intrq_o}, 2'b10);
    endtask

    task automatic t_disable();
        do_reset(1'b0);
        irq_dis = 1'b1; wait_neg(2);
        check("R2 disabled released", {intrq_oe, intrq_o}, 2'b00);
        ev_set(); wait_neg(2);
        check("R2 disabled with pending", {intrq_oe, intrq_o}, 2'b00);
        irq_dis = 1'b0; wait_neg(2);
        check("R2 enable shows pending", {intrq_oe, intrq_o}, 2'b11);
    endtask

    task automatic t_desel_resel();
        do_reset(1'b0);
        ev_set(); wait_neg(MIN_PULSE + 2);
        ev_dev(1'b1); wait_neg(2);
        check("R6 deselect releases", {intrq_oe, intrq_o}, 2'b00);
        wait_neg(10);
        ev_dev(1'b0); wait_neg(2);
        check("R5 reselect drives high", {intrq_oe, intrq_o}, 2'b11);
        check("R6 pending kept", {1'b0, intrq_o}, 2'b01);
    endtask

    task automatic t_priority();
        do_reset(1'b0);
        pend_set = 1'b1; stat_rd = 1'b1; cmd_wr = 1'b1;
        wait_neg(1);
        pend_set = 1'b0; stat_rd = 1'b0; cmd_wr = 1'b0;
        wait_neg(2);
        check("R8 set beats clear", {intrq_oe, intrq_o}, 2'b11);
    endtask

    task automatic t_min_pulse();
        int hi;
        int lat;
        do_reset(1'b0);
        ev_set();
        lat = 0;
        while (intrq_o !== 1'b1 && lat < LIMIT) begin wait_neg(1); lat++; end
        check("R9 assert latency", {1'b0, lat <= 2}, 2'b01);
        irq_dis = 1'b1;
        hi = 0;
        while (intrq_o === 1'b1 && hi < LIMIT) begin hi++; wait_neg(1); end
        check("R7 pulse width", {1'b0, hi >= MIN_PULSE}, 2'b01);
        check("R9 release within limit", {1'b0, hi < LIMIT}, 2'b01);
        check("R7 released after hold", {intrq_oe, intrq_o}, 2'b00);
        irq_dis = 1'b0;
    endtask

    task automatic t_dev1();
        do_reset(1'b1);
        check("R1 dev1 reset released", {intrq_oe, intrq_o}, 2'b00);
        ev_set(); wait_neg(2);
        check("R10 dev1 unselected", {intrq_oe, intrq_o}, 2'b00);
        ev_dev(1'b1); wait_neg(2);
        check("R10 select bit 1 picks dev1", {intrq_oe, intrq_o}, 2'b11);
        wait_neg(MIN_PULSE);
        ev_dev(1'b0); wait_neg(2);
        check("R10 select bit 0 drops dev1", {intrq_oe, intrq_o}, 2'b00);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_status_clear();
                t_cmd_clear();
                t_disable();
                t_desel_resel();
                t_priority();
                t_min_pulse();
                t_dev1();
            end
            begin
                wait_neg(20000);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule